// File: doc/BRIEF.md
# Receive FIFO with Threshold Flag

This block buffers received bytes for a serial port and tells software when enough of them have piled up to be worth fetching. The receiver pushes one byte per strobe into a 16-entry first-in first-out store. Bytes leave through a data read port that either the CPU or a DMA engine can strobe. A registered fill count is reported in an 8-bit field. A sticky data-full flag rises whenever the fill count is at or above a threshold picked by a 2-bit control field.

The flag has two clearing paths. On the CPU path the flag must first be read as 1 through the status port, which arms an internal bit. A later clear request (writing 0 to the flag) is honoured only if it arrives while the block is armed and after data reads have taken the fill count below the threshold. On the DMA path, a DMA read that leaves the count below the threshold clears the flag with no CPU write. A standby request or reset drops the flag and the armed bit.

All outputs except the read data are registered. A request sampled at a clock edge is visible at the outputs just after that edge.

Top module: `rxq_trig_fifo`

## Requirements
- R1: The store holds up to 16 bytes in arrival order; `pop_data_o` always shows the oldest stored byte, and a CPU or DMA read strobe removes it.
- R2: `fill_count_o` gives the number of stored bytes in its low bits with the upper bits zero; a push and a read in the same cycle leave the count unchanged.
- R3: A push while 16 bytes are stored and no read is made is dropped, and `overflow_o` is 1 for exactly the following cycle; a push together with a read at 16 bytes is accepted with no overflow.
- R4: A read strobe while the store is empty changes neither the count nor the stored contents.
- R5: The trigger field written through `ctrl_we_i` encodes 00 as 1 byte, 01 as 4, 10 as 8 and 11 as 14; outside a standby cycle, the flag is 1 in every cycle where the fill count is at or above the selected level.
- R6: CPU reads alone never clear the flag, and a clear request made without a prior status read of 1 leaves the flag at 1.
- R7: A status read that sees the flag at 1 arms the block; a clear request while armed and with the count below the level drops the flag in the next cycle and disarms.
- R8: A clear request while armed but with the count still at or above the level leaves the flag at 1.
- R9: A DMA read that leaves the count below the level clears the flag in the next cycle without any clear request.
- R10: Reset or a standby request forces the flag to 0 and disarms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby_i | input | 1 | Standby request; clears flag and arming |
| ctrl_we_i | input | 1 | Write strobe for the trigger field |
| ctrl_trig_i | input | 2 | New trigger field value |
| push_i | input | 1 | Receiver push strobe |
| push_data_i | input | 8 | Received byte |
| cpu_pop_i | input | 1 | CPU read strobe of the data port |
| dma_pop_i | input | 1 | DMA read strobe of the data port |
| pop_data_o | output | 8 | Oldest stored byte (undefined when empty) |
| stat_rd_i | input | 1 | CPU read of the status flag |
| flag_clr_i | input | 1 | CPU write of 0 to the status flag |
| full_flag_o | output | 1 | Data-full flag |
| fill_count_o | output | 8 | Number of stored bytes |
| overflow_o | output | 1 | One-cycle pulse after a dropped push |

## Verification
The checker assumes every strobe is a clean one-cycle-per-request level sampled at the rising edge. It also assumes a read at an empty store is only a no-op, never a source of data. The bench keeps to this by driving every input at the falling edge and holding it for exactly one cycle. The bench also treats `pop_data_o` as meaningful only when its reference queue is not empty. For each of the four trigger settings, the stimulus walks the count from 0 through overflow and back. The walk uses CPU reads, DMA reads, clear attempts before and after arming, and standby. It never asserts standby and a status read together, so the arming rule is seen on its own.

// File: rtl/rxq_pkg.sv
// Package: shared constants and the trigger-field decode for the receive FIFO.
// Assumes the trigger field is two bits wide; every encoding maps to a level.
package rxq_pkg;

    localparam int unsigned RXQ_TRIG_W = 2;

    typedef logic [RXQ_TRIG_W-1:0] rxq_trig_t;

    // Byte count selected by each trigger encoding.
    function automatic int unsigned rxq_trig_level(input rxq_trig_t sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
// Module: circular byte store with read/write pointers and an occupancy count.
// Assumes DEPTH >= 2. A push at full is dropped unless a read happens in the
// same cycle. A read at empty is ignored. The drop is reported one cycle late.
module rxq_store #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  cnt_next_o,
    output logic              drop_o
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              pop_ok, push_ok, drop_q;

    // Pointer advance with explicit wrap so DEPTH need not be a power of two.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // Decide which requests take effect this cycle and the next occupancy.
    always_comb begin
        pop_ok  = pop_i && (cnt_q != '0);
        push_ok = push_i && ((cnt_q != FULL_CNT) || pop_ok);
        cnt_d   = cnt_q;
        if (push_ok && !pop_ok)
            cnt_d = cnt_q + 1'b1;
        else if (pop_ok && !push_ok)
            cnt_d = cnt_q - 1'b1;
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr_q] <= push_data_i;
    end

    // Pointers, count and the registered drop pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
            drop_q   <= 1'b0;
        end else begin
            if (push_ok) wr_ptr_q <= bump(wr_ptr_q);
            if (pop_ok)  rd_ptr_q <= bump(rd_ptr_q);
            cnt_q  <= cnt_d;
            drop_q <= push_i && !push_ok;
        end
    end

    assign head_o     = mem[rd_ptr_q];
    assign cnt_o      = cnt_q;
    assign cnt_next_o = cnt_d;
    assign drop_o     = drop_q;

endmodule

// File: rtl/rxq_ctrl_reg.sv
// Module: holds the trigger-select field of the control register.
// Assumes a write strobe loads the field at the clock edge. It also exposes
// the value the field will hold after this edge, so that dependent state
// can update in step.
module rxq_ctrl_reg
    import rxq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we_i,
    input  rxq_trig_t trig_i,
    output rxq_trig_t sel_o,
    output rxq_trig_t sel_next_o
);
    rxq_trig_t sel_q;

    // Next value of the field.
    assign sel_next_o = we_i ? trig_i : sel_q;

    // Field register, reset to the smallest threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_next_o;
    end

    assign sel_o = sel_q;

endmodule

// File: rtl/rxq_level_flag.sv
// Module: data-full flag with threshold compare, arming bit and both clear paths.
// Assumes cnt_next_i and sel_next_i are the count and trigger select that take
// effect at this edge, so the flag stays aligned with the registered count.
// Priority: standby, then the threshold set, then the DMA or armed CPU clear.
module rxq_level_flag
    import rxq_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  rxq_trig_t        sel_next_i,
    input  logic             dma_pop_i,
    input  logic             stat_rd_i,
    input  logic             flag_clr_i,
    output logic             flag_o
);
    logic [CNT_W-1:0] lvl_next;
    logic             below, clr_ok;
    logic             flag_q, flag_d, armed_q, armed_d;

    // Next-state logic for the flag and arming bit.
    always_comb begin
        lvl_next = CNT_W'(rxq_trig_level(sel_next_i));
        below    = cnt_next_i < lvl_next;
        clr_ok   = flag_clr_i && armed_q && below;
        flag_d   = flag_q;
        armed_d  = armed_q;
        if (standby_i) begin
            flag_d  = 1'b0;
            armed_d = 1'b0;
        end else begin
            if (!below)
                flag_d = 1'b1;
            else if (dma_pop_i || clr_ok)
                flag_d = 1'b0;
            if (clr_ok)
                armed_d = 1'b0;
            else if (stat_rd_i)
                armed_d = flag_q;
        end
    end

    // Flag and arming registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            flag_q  <= flag_d;
            armed_q <= armed_d;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/rxq_trig_fifo.sv
// Module: top of the receive FIFO with threshold flag.
// Connects the byte store, the control field and the flag logic. CPU and DMA
// reads share the data port; only the DMA strobe feeds the automatic clear.
// Assumes fill_count_o is wide enough for DEPTH.
module rxq_trig_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OUT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic              ctrl_we_i,
    input  logic [1:0]        ctrl_trig_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              cpu_pop_i,
    input  logic              dma_pop_i,
    output logic [DATA_W-1:0] pop_data_o,
    input  logic              stat_rd_i,
    input  logic              flag_clr_i,
    output logic              full_flag_o,
    output logic [OUT_W-1:0]  fill_count_o,
    output logic              overflow_o
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] cnt, cnt_next, trig_lvl;
    rxq_trig_t        sel, sel_next;
    logic             any_pop;

    // Either master's read strobe removes one byte.
    assign any_pop = cpu_pop_i || dma_pop_i;

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .push_data_i (push_data_i),
        .pop_i       (any_pop),
        .head_o      (pop_data_o),
        .cnt_o       (cnt),
        .cnt_next_o  (cnt_next),
        .drop_o      (overflow_o)
    );

    rxq_ctrl_reg ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (ctrl_we_i),
        .trig_i     (ctrl_trig_i),
        .sel_o      (sel),
        .sel_next_o (sel_next)
    );

    rxq_level_flag #(.CNT_W(CNT_W)) flag_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby_i  (standby_i),
        .cnt_next_i (cnt_next),
        .sel_next_i (sel_next),
        .dma_pop_i  (dma_pop_i),
        .stat_rd_i  (stat_rd_i),
        .flag_clr_i (flag_clr_i),
        .flag_o     (full_flag_o)
    );

    // Current threshold, used by the bound checker.
    assign trig_lvl     = CNT_W'(rxq_trig_level(sel));
    assign fill_count_o = OUT_W'(cnt);

endmodule

// File: rtl/rxq_trig_fifo_chk.sv
// Checker: temporal properties of the receive FIFO, bound to the top module.
// Assumes inputs are sampled at the rising edge and reset is synchronous.
module rxq_trig_fifo_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 5,
    parameter int unsigned OUT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             standby_i,
    input logic             push_i,
    input logic             cpu_pop_i,
    input logic             dma_pop_i,
    input logic             flag_clr_i,
    input logic             full_flag_o,
    input logic [OUT_W-1:0] fill_count_o,
    input logic             overflow_o,
    input logic [CNT_W-1:0] trig_lvl
);
    localparam logic [OUT_W-1:0] FULL_CNT = OUT_W'(DEPTH);
    localparam logic [OUT_W-1:0] LVL_PAD  = '0;

    // R2: count never exceeds the depth.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count_o <= FULL_CNT);

    // R2: a lone accepted push raises the count by one.
    a_r2_push_incr: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !cpu_pop_i && !dma_pop_i && fill_count_o < FULL_CNT)
        |=> fill_count_o == $past(fill_count_o) + 1'b1);

    // R3: a push at full with no read produces the overflow pulse.
    a_r3_overflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !cpu_pop_i && !dma_pop_i && fill_count_o == FULL_CNT)
        |=> overflow_o);

    // R4: reads at empty without a push keep the store empty.
    a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count_o == LVL_PAD && !push_i) |=> fill_count_o == LVL_PAD);

    // R5: the flag is set whenever the count reaches the level.
    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_i |=> (fill_count_o < (LVL_PAD | OUT_W'(trig_lvl)) || full_flag_o));

    // R6: the flag only falls through standby, a DMA read or a clear request.
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (full_flag_o && !standby_i && !dma_pop_i && !flag_clr_i) |=> full_flag_o);

    // R10: standby forces the flag low.
    a_r10_standby_clear: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> !full_flag_o);

endmodule

bind rxq_trig_fifo rxq_trig_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OUT_W(OUT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .standby_i    (standby_i),
    .push_i       (push_i),
    .cpu_pop_i    (cpu_pop_i),
    .dma_pop_i    (dma_pop_i),
    .flag_clr_i   (flag_clr_i),
    .full_flag_o  (full_flag_o),
    .fill_count_o (fill_count_o),
    .overflow_o   (overflow_o),
    .trig_lvl     (trig_lvl)
);

// File: tb/rxq_trig_fifo_tb_top.sv
// Bench: sweeps all four trigger settings through fill, overflow, CPU drain
// with arming, DMA drain, empty reads, concurrent push/read and standby.
module rxq_trig_fifo_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       standby_i, ctrl_we_i, push_i, cpu_pop_i, dma_pop_i;
    logic       stat_rd_i, flag_clr_i;
    logic [1:0] ctrl_trig_i;
    logic [7:0] push_data_i, pop_data_o, fill_count_o;
    logic       full_flag_o, overflow_o;

    int         n_vec = 0;
    int         n_bad = 0;
    logic [7:0] mq[$];
    int         m_sel = 0;
    bit         m_flag = 1'b0;
    bit         m_arm = 1'b0;

    always #4 clk = ~clk;

    rxq_trig_fifo dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .standby_i    (standby_i),
        .ctrl_we_i    (ctrl_we_i),
        .ctrl_trig_i  (ctrl_trig_i),
        .push_i       (push_i),
        .push_data_i  (push_data_i),
        .cpu_pop_i    (cpu_pop_i),
        .dma_pop_i    (dma_pop_i),
        .pop_data_o   (pop_data_o),
        .stat_rd_i    (stat_rd_i),
        .flag_clr_i   (flag_clr_i),
        .full_flag_o  (full_flag_o),
        .fill_count_o (fill_count_o),
        .overflow_o   (overflow_o)
    );

    function automatic int lvl(input int s);
        case (s)
            0:       return 1;
            1:       return 4;
            2:       return 8;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        standby_i = 0; ctrl_we_i = 0; ctrl_trig_i = 0; push_i = 0; push_data_i = 0;
        cpu_pop_i = 0; dma_pop_i = 0; stat_rd_i = 0; flag_clr_i = 0;
    endtask

    // One cycle: drive at the falling edge, predict, compare at the next one.
    task automatic step(input string ftag, input bit push, input logic [7:0] d,
                        input bit cpu, input bit dma, input bit srd, input bit clr,
                        input bit stby, input bit cw, input int cv);
        bit popv, pushok, ovf, below, clr_ok;
        int cnt_n, sel_n;
        push_i = push; push_data_i = d; cpu_pop_i = cpu; dma_pop_i = dma;
        stat_rd_i = srd; flag_clr_i = clr; standby_i = stby;
        ctrl_we_i = cw; ctrl_trig_i = 2'(cv);
        #1;
        popv   = (cpu || dma) && (mq.size() > 0);
        pushok = push && ((mq.size() < 16) || popv);
        ovf    = push && !pushok;
        if (popv) begin
            chk("R1 head byte", int'(pop_data_o), int'(mq[0]));
            void'(mq.pop_front());
        end
        if (pushok) mq.push_back(d);
        cnt_n  = mq.size();
        sel_n  = cw ? cv : m_sel;
        below  = cnt_n < lvl(sel_n);
        clr_ok = clr && m_arm && below;
        if (stby) begin
            m_flag = 0; m_arm = 0;
        end else begin
            if (!below)              m_flag = 1;
            else if (dma || clr_ok)  m_flag = 0;
            if (clr_ok)              m_arm = 0;
            else if (srd)            m_arm = full_flag_o;
        end
        m_sel = sel_n;
        @(negedge clk);
        idle_inputs();
        chk("R2 fill count", int'(fill_count_o), cnt_n);
        chk(ftag, int'(full_flag_o), int'(m_flag));
        chk("R3 overflow pulse", int'(overflow_o), int'(ovf));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R2 reset count", int'(fill_count_o), 0);
        chk("R10 reset flag", int'(full_flag_o), 0);
        chk("R3 reset overflow", int'(overflow_o), 0);
        rst_n = 1;
        @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            step("R5 trigger write", 0, 0, 0, 0, 0, 0, 0, 1, s);
            // Fill past full: R5 flag tracks level, R3 overflow on extra pushes.
            for (int i = 0; i < 18; i++)
                step("R5 flag on fill", 1, 8'(s * 32 + i), 0, 0, 0, 0, 0, 0, 0);
            // R6: CPU reads alone keep the flag up.
            while (mq.size() >= lvl(s))
                step("R6 cpu read keeps flag", 0, 0, 1, 0, 0, 0, 0, 0, 0);
            step("R6 unarmed clear ignored", 0, 0, 0, 0, 0, 1, 0, 0, 0);
            step("R7 arming read", 0, 0, 0, 0, 1, 0, 0, 0, 0);
            step("R7 armed clear", 0, 0, 0, 0, 0, 1, 0, 0, 0);
            step("R7 read of zero", 0, 0, 0, 0, 1, 0, 0, 0, 0);
            while (mq.size() > 0)
                step("R1 cpu drain", 0, 0, 1, 0, 0, 0, 0, 0, 0);
            // R8: clear while still at or above level is refused.
            for (int i = 0; i < 16; i++)
                step("R5 refill", 1, 8'(s * 16 + i + 100), 0, 0, 0, 0, 0, 0, 0);
            step("R3 push with read at full", 1, 8'hA5, 1, 0, 0, 0, 0, 0, 0);
            step("R8 arming read", 0, 0, 0, 0, 1, 0, 0, 0, 0);
            step("R8 clear above level", 0, 0, 0, 0, 0, 1, 0, 0, 0);
            // R9: DMA drain clears the flag on its own.
            while (mq.size() > 0)
                step("R9 dma drain", 0, 0, 0, 1, 0, 0, 0, 0, 0);
            // R4: reads at empty change nothing.
            step("R4 cpu read empty", 0, 0, 1, 0, 0, 0, 0, 0, 0);
            step("R4 dma read empty", 0, 0, 0, 1, 0, 0, 0, 0, 0);
            // R2: concurrent push and read hold the count.
            step("R2 seed", 1, 8'h3C, 0, 0, 0, 0, 0, 0, 0);
            for (int i = 0; i < 3; i++)
                step("R2 push with read", 1, 8'(200 + i), (i % 2) == 0, (i % 2) == 1, 0, 0, 0, 0, 0);
            for (int i = 0; i < 14; i++)
                step("R5 top up", 1, 8'(i + 60), 0, 0, 0, 0, 0, 0, 0);
            // R10: standby drops the flag, which then re-sets from the level.
            step("R10 standby", 0, 0, 0, 0, 0, 0, 1, 0, 0);
            step("R10 after standby", 0, 0, 0, 0, 0, 0, 0, 0, 0);
            while (mq.size() > 0)
                step("R1 final drain", 0, 0, 1, 0, 0, 0, 0, 0, 0);
            step("R10 disarm", 0, 0, 0, 0, 0, 0, 1, 0, 0);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule